// File: doc/BRIEF.md
# Serial EEPROM Word-Address Pointer and Page Buffer

This block keeps the internal word-address counter of a serial EEPROM slave, one access session at a time. The protocol engine tells it when a word address has arrived, when a data byte has been received in a write, when a byte has been sent in a read, and when the stop condition arrives. The pointer it holds survives between sessions, so a later session that reads from the current address starts where the previous one left off.

The wrap rule depends on the address space being addressed. Each of the two banks reached through its own port is an 8-bit space. The combined view from the control port is a single 9-bit space, in which bank 1 is followed directly by bank 2. The configuration area is a 4-bit space. Writes are different: only the low four address bits move, so a burst of write data circles inside one 16-byte page.

Received write bytes are collected in a 16-slot page buffer with a per-slot valid mask. Nothing is handed to the memory array until the stop condition. At that point the block presents the page base, the mask, the space and the buffered bytes for one cycle.

Top module: `eeprom_addr_ptr`

## Requirements
- R1: After synchronous reset, `cur_addr_o` is 0 and `commit_valid_o` is 0.
- R2: A load takes the address that fits the selected space, with `space_i` encoded as 0 = bank 1, 1 = bank 2, 2 = combined, 3 = configuration. The banks keep bits 7..0 and clear bit 8. The combined space keeps all 9 bits. The configuration space keeps bits 3..0 and clears bits 8..4.
- R3: A write step (`step_i` with `wr_mode_i` = 1) increments only address bits 3..0, wrapping from offset Fh to offset 0 of the same page. Bits 8..4 are unchanged. A byte written at offset Fh therefore leaves the pointer at offset 0 of its page.
- R4: When the same page offset is written more than once in a session, the commit carries the byte written last. Byte k of the page sits at `commit_data_o[8k+7:8k]`.
- R5: `commit_valid_o` rises only in the cycle after `stop_i`, and only if at least one byte is buffered. It lasts exactly one cycle. With it come `commit_base_o`, which is the pointer with bits 3..0 cleared, and `commit_mask_o`, which has bit k set for each written offset k.
- R6: A read step (`step_i` with `wr_mode_i` = 0) in a bank space counts modulo 256, so FFh becomes 000h.
- R7: A read step in the combined space counts modulo 512, so 0FFh becomes 100h and 1FFh becomes 000h.
- R8: A read step in the configuration space counts modulo 16, so Fh becomes 0h.
- R9: A write to configuration offset Fh, the revision code, is not buffered: its mask bit stays clear in the commit. The pointer still advances. Other configuration offsets behave as ordinary storage.
- R10: A load discards any bytes buffered before it. An address-only write session, such as the dummy write of a random read, followed by stop produces no commit.
- R11: The pointer holds its value when neither load nor step is asserted, including across a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| space_i | input | 2 | Target space: 0 bank 1, 1 bank 2, 2 combined, 3 configuration |
| load_i | input | 1 | Word address received; has priority over step |
| load_addr_i | input | 9 | Received word address (bit 8 is the bank select in combined space) |
| step_i | input | 1 | One data byte transferred |
| wr_mode_i | input | 1 | 1 = the step is a received write byte, 0 = a sent read byte |
| wr_data_i | input | 8 | Write byte captured on a write step |
| stop_i | input | 1 | Stop condition seen |
| cur_addr_o | output | 9 | Current word-address pointer |
| commit_valid_o | output | 1 | One-cycle commit pulse |
| commit_space_o | output | 2 | Space of the committed page |
| commit_base_o | output | 9 | Base address of the committed page |
| commit_mask_o | output | 16 | Written-offset mask of the committed page |
| commit_data_o | output | 128 | Buffered page bytes, byte k at bits 8k+7..8k |

## Verification
The bench builds the block with its default parameters: 8-bit banks, a 4-bit configuration space and 16-byte pages. These are the only values at which the 0FFh-to-100h crossing, the 1FFh wrap and the revision-code slot at configuration offset Fh exist as the bench's table encodes them. With those widths, a 17-byte burst that starts at offset Eh wraps the page and overwrites its first slot, within a few dozen cycles. The same run also crosses every space's read wrap point.

// File: rtl/eap_pkg.sv
package eap_pkg;

    // Target address space of a session
    typedef enum logic [1:0] {
        SP_BANK1 = 2'd0,
        SP_BANK2 = 2'd1,
        SP_COMB  = 2'd2,
        SP_CFG   = 2'd3
    } space_e;

    function automatic logic is_bank(space_e s);
        return (s == SP_BANK1) || (s == SP_BANK2);
    endfunction

endpackage

// File: rtl/eap_next_addr.sv
module eap_next_addr
    import eap_pkg::*;
#(
    parameter int BANK_AW = 8,
    parameter int PAGE_AW = 4,
    parameter int CFG_AW  = 4,
    localparam int AW     = BANK_AW + 1
) (
    input  logic [AW-1:0] cur_i,
    input  space_e        space_i,
    input  logic          load_i,
    input  logic [AW-1:0] load_addr_i,
    input  logic          step_i,
    input  logic          wr_mode_i,
    output logic [AW-1:0] nxt_o
);

    logic [PAGE_AW-1:0] page_inc;
    logic [BANK_AW-1:0] bank_inc;
    logic [CFG_AW-1:0]  cfg_inc;
    logic [AW-1:0]      comb_inc;

    assign page_inc = cur_i[PAGE_AW-1:0] + PAGE_AW'(1);
    assign bank_inc = cur_i[BANK_AW-1:0] + BANK_AW'(1);
    assign cfg_inc  = cur_i[CFG_AW-1:0] + CFG_AW'(1);
    assign comb_inc = cur_i + AW'(1);

    always_comb begin
        nxt_o = cur_i;
        if (load_i) begin
            unique case (space_i)
                SP_COMB: nxt_o = load_addr_i;
                SP_CFG:  nxt_o = AW'(load_addr_i[CFG_AW-1:0]);
                default: nxt_o = AW'(load_addr_i[BANK_AW-1:0]);
            endcase
        end else if (step_i && wr_mode_i) begin
            nxt_o = {cur_i[AW-1:PAGE_AW], page_inc};
        end else if (step_i) begin
            unique case (space_i)
                SP_COMB: nxt_o = comb_inc;
                SP_CFG:  nxt_o = AW'(cfg_inc);
                default: nxt_o = AW'(bank_inc);
            endcase
        end
    end

endmodule

// File: rtl/eap_page_buf.sv
module eap_page_buf
    import eap_pkg::*;
#(
    parameter int AW      = 9,
    parameter int PAGE_AW = 4,
    parameter int DW      = 8,
    localparam int PAGE_BYTES = 1 << PAGE_AW
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr_i,
    input  logic                     wr_i,
    input  logic                     block_i,
    input  logic [PAGE_AW-1:0]       off_i,
    input  logic [DW-1:0]            data_i,
    input  logic                     stop_i,
    input  logic [AW-1:0]            base_i,
    input  space_e                   space_i,
    output logic                     commit_valid_o,
    output space_e                   commit_space_o,
    output logic [AW-1:0]            commit_base_o,
    output logic [PAGE_BYTES-1:0]    commit_mask_o,
    output logic [PAGE_BYTES*DW-1:0] commit_data_o
);

    logic [PAGE_BYTES-1:0] mask_q;
    logic                  accept;

    assign accept = wr_i && !block_i;

    // One storage slot per page offset
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic [DW-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (accept && (off_i == PAGE_AW'(g))) begin
                slot_q <= data_i;
            end
        end
        assign commit_data_o[g*DW +: DW] = slot_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (clr_i || stop_i) begin
            mask_q <= '0;
        end else if (accept) begin
            mask_q[off_i] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            commit_valid_o <= 1'b0;
            commit_space_o <= SP_BANK1;
            commit_base_o  <= '0;
            commit_mask_o  <= '0;
        end else begin
            commit_valid_o <= stop_i && (|mask_q);
            if (stop_i) begin
                commit_space_o <= space_i;
                commit_base_o  <= base_i;
                commit_mask_o  <= mask_q;
            end
        end
    end

    // R5
    commit_cause_chk: assert property (@(posedge clk) disable iff (rst)
        commit_valid_o |-> $past(stop_i));

    // R5
    commit_single_chk: assert property (@(posedge clk) disable iff (rst)
        commit_valid_o |=> !commit_valid_o);

    // R9
    cfg_rev_chk: assert property (@(posedge clk) disable iff (rst)
        (commit_valid_o && commit_space_o == SP_CFG) |-> !commit_mask_o[PAGE_BYTES-1]);

endmodule

// File: rtl/eeprom_addr_ptr.sv
module eeprom_addr_ptr
    import eap_pkg::*;
#(
    parameter int BANK_AW = 8,
    parameter int PAGE_AW = 4,
    parameter int CFG_AW  = 4,
    parameter int DW      = 8,
    localparam int AW         = BANK_AW + 1,
    localparam int PAGE_BYTES = 1 << PAGE_AW
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [1:0]               space_i,
    input  logic                     load_i,
    input  logic [AW-1:0]            load_addr_i,
    input  logic                     step_i,
    input  logic                     wr_mode_i,
    input  logic [DW-1:0]            wr_data_i,
    input  logic                     stop_i,
    output logic [AW-1:0]            cur_addr_o,
    output logic                     commit_valid_o,
    output logic [1:0]               commit_space_o,
    output logic [AW-1:0]            commit_base_o,
    output logic [PAGE_BYTES-1:0]    commit_mask_o,
    output logic [PAGE_BYTES*DW-1:0] commit_data_o
);

    localparam logic [AW-1:0] BANK1_END  = AW'((1 << BANK_AW) - 1);
    localparam logic [AW-1:0] BANK2_BASE = AW'(1 << BANK_AW);

    space_e        sp;
    space_e        c_space;
    logic [AW-1:0] cur_q;
    logic [AW-1:0] nxt;
    logic          rev_slot;

    assign sp       = space_e'(space_i);
    assign rev_slot = (sp == SP_CFG) && (&cur_q[CFG_AW-1:0]);

    eap_next_addr #(
        .BANK_AW(BANK_AW),
        .PAGE_AW(PAGE_AW),
        .CFG_AW (CFG_AW)
    ) u_next (
        .cur_i      (cur_q),
        .space_i    (sp),
        .load_i     (load_i),
        .load_addr_i(load_addr_i),
        .step_i     (step_i),
        .wr_mode_i  (wr_mode_i),
        .nxt_o      (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt;
        end
    end

    eap_page_buf #(
        .AW     (AW),
        .PAGE_AW(PAGE_AW),
        .DW     (DW)
    ) u_page (
        .clk           (clk),
        .rst           (rst),
        .clr_i         (load_i),
        .wr_i          (step_i && wr_mode_i && !load_i),
        .block_i       (rev_slot),
        .off_i         (cur_q[PAGE_AW-1:0]),
        .data_i        (wr_data_i),
        .stop_i        (stop_i),
        .base_i        ({cur_q[AW-1:PAGE_AW], PAGE_AW'(0)}),
        .space_i       (sp),
        .commit_valid_o(commit_valid_o),
        .commit_space_o(c_space),
        .commit_base_o (commit_base_o),
        .commit_mask_o (commit_mask_o),
        .commit_data_o (commit_data_o)
    );

    assign commit_space_o = c_space;
    assign cur_addr_o     = cur_q;

    // R3
    page_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && wr_mode_i && !load_i) |=>
            (cur_q[AW-1:PAGE_AW] == $past(cur_q[AW-1:PAGE_AW])));

    // R6
    bank_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && !wr_mode_i && !load_i && is_bank(sp) && (&cur_q[BANK_AW-1:0]))
            |=> (cur_q == '0));

    // R7
    comb_cross_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && !wr_mode_i && !load_i && sp == SP_COMB && cur_q == BANK1_END)
            |=> (cur_q == BANK2_BASE));

    // R11
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !step_i) |=> $stable(cur_q));

endmodule

// File: tb/eeprom_addr_ptr_tb.sv
`timescale 1ns/1ps
module eeprom_addr_ptr_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   space_i;
    logic         load_i;
    logic [8:0]   load_addr_i;
    logic         step_i;
    logic         wr_mode_i;
    logic [7:0]   wr_data_i;
    logic         stop_i;
    logic [8:0]   cur_addr_o;
    logic         commit_valid_o;
    logic [1:0]   commit_space_o;
    logic [8:0]   commit_base_o;
    logic [15:0]  commit_mask_o;
    logic [127:0] commit_data_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    eeprom_addr_ptr dut_i (
        .clk(clk), .rst(rst), .space_i(space_i), .load_i(load_i),
        .load_addr_i(load_addr_i), .step_i(step_i), .wr_mode_i(wr_mode_i),
        .wr_data_i(wr_data_i), .stop_i(stop_i), .cur_addr_o(cur_addr_o),
        .commit_valid_o(commit_valid_o), .commit_space_o(commit_space_o),
        .commit_base_o(commit_base_o), .commit_mask_o(commit_mask_o),
        .commit_data_o(commit_data_o)
    );

    // op: 0 load, 1 read step, 2 write step
    // {op[30:28], space[27:26], addr[25:17], data[16:9], exp_addr[8:0]}
    localparam int NV = 15;
    localparam logic [30:0] VEC [NV] = '{
        {3'd0, 2'd0, 9'h1FE, 8'h00, 9'h0FE},  // R2 bank drops bit 8
        {3'd1, 2'd0, 9'h000, 8'h00, 9'h0FF},  // R6
        {3'd1, 2'd0, 9'h000, 8'h00, 9'h000},  // R6 FF -> 00
        {3'd0, 2'd2, 9'h0FF, 8'h00, 9'h0FF},  // R2 combined keeps 9 bits
        {3'd1, 2'd2, 9'h000, 8'h00, 9'h100},  // R7 0FF -> 100
        {3'd0, 2'd2, 9'h1FF, 8'h00, 9'h1FF},
        {3'd1, 2'd2, 9'h000, 8'h00, 9'h000},  // R7 1FF -> 000
        {3'd0, 2'd3, 9'h1AE, 8'h00, 9'h00E},  // R2 config keeps 4 bits
        {3'd1, 2'd3, 9'h000, 8'h00, 9'h00F},  // R8
        {3'd1, 2'd3, 9'h000, 8'h00, 9'h000},  // R8 F -> 0
        {3'd0, 2'd1, 9'h05E, 8'h00, 9'h05E},
        {3'd2, 2'd1, 9'h000, 8'hA1, 9'h05F},  // R3
        {3'd2, 2'd1, 9'h000, 8'hA2, 9'h050},  // R3 page wrap
        {3'd0, 2'd2, 9'h1FF, 8'h00, 9'h1FF},
        {3'd2, 2'd2, 9'h000, 8'hA3, 9'h1F0}   // R3 no carry into bit 4
    };

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a negedge; applies one cycle of stimulus and returns at the next negedge
    task automatic op(input logic [2:0] o, input logic [1:0] sp, input logic [8:0] a, input logic [7:0] d);
        space_i     = sp;
        load_i      = (o == 3'd0);
        load_addr_i = a;
        step_i      = (o != 3'd0);
        wr_mode_i   = (o == 3'd2);
        wr_data_i   = d;
        @(negedge clk);
        load_i = 1'b0;
        step_i = 1'b0;
    endtask

    task automatic do_stop();
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] exp_data;
        rst = 1'b1; space_i = 2'd0; load_i = 1'b0; load_addr_i = '0;
        step_i = 1'b0; wr_mode_i = 1'b0; wr_data_i = '0; stop_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset pointer", 128'(cur_addr_o), 128'h0);
        chk("R1 reset commit", 128'(commit_valid_o), 128'h0);

        for (int i = 0; i < NV; i++) begin
            op(VEC[i][30:28], VEC[i][27:26], VEC[i][25:17], VEC[i][16:9]);
            chk($sformatf("R2/R3/R6/R7/R8 vector %0d", i), 128'(cur_addr_o), 128'(VEC[i][8:0]));
        end

        // R4/R5: 17 bytes from 03Eh in bank 2, offset E is written twice
        op(3'd0, 2'd1, 9'h03E, 8'h00);
        exp_data = '0;
        for (int i = 0; i < 17; i++) begin
            op(3'd2, 2'd1, 9'h000, 8'(8'h10 + i));
            exp_data[((14 + i) % 16) * 8 +: 8] = 8'(8'h10 + i);
        end
        chk("R5 no commit before stop", 128'(commit_valid_o), 128'h0);
        chk("R3 pointer after 17 bytes", 128'(cur_addr_o), 128'h03F);
        do_stop();
        chk("R5 commit pulse", 128'(commit_valid_o), 128'h1);
        chk("R5 commit base", 128'(commit_base_o), 128'h030);
        chk("R5 commit mask", 128'(commit_mask_o), 128'hFFFF);
        chk("R5 commit space", 128'(commit_space_o), 128'h1);
        chk("R4 last byte kept", commit_data_o, exp_data);
        chk("R11 pointer across stop", 128'(cur_addr_o), 128'h03F);
        @(negedge clk);
        chk("R5 pulse one cycle", 128'(commit_valid_o), 128'h0);

        // R10: dummy write then stop
        op(3'd0, 2'd0, 9'h012, 8'h00);
        do_stop();
        chk("R10 dummy write no commit", 128'(commit_valid_o), 128'h0);
        chk("R10 pointer loaded", 128'(cur_addr_o), 128'h012);
        // R10: buffered byte discarded by a new load
        op(3'd2, 2'd0, 9'h000, 8'h99);
        op(3'd0, 2'd0, 9'h040, 8'h00);
        do_stop();
        chk("R10 load discards bytes", 128'(commit_valid_o), 128'h0);

        // R9: revision slot ignored, pointer still advances
        op(3'd0, 2'd3, 9'h00E, 8'h00);
        op(3'd2, 2'd3, 9'h000, 8'h55);
        op(3'd2, 2'd3, 9'h000, 8'h66);
        chk("R9 pointer advances past Fh", 128'(cur_addr_o), 128'h000);
        do_stop();
        chk("R9 commit present", 128'(commit_valid_o), 128'h1);
        chk("R9 revision slot masked", 128'(commit_mask_o), 128'h4000);
        chk("R9 offset E data", 128'(commit_data_o[14*8 +: 8]), 128'h55);
        @(negedge clk);

        // R9: reserved configuration offset is plain storage
        op(3'd0, 2'd3, 9'h003, 8'h00);
        op(3'd2, 2'd3, 9'h000, 8'h77);
        do_stop();
        chk("R9 reserved offset stored", 128'(commit_mask_o), 128'h0008);
        chk("R9 reserved offset data", 128'(commit_data_o[3*8 +: 8]), 128'h77);
        @(negedge clk);
        chk("R11 hold idle", 128'(cur_addr_o), 128'h004);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule